// File: doc/BRIEF.md
# ADC Result Threshold Monitor

This block sits behind a converter's digital filter and looks at every signed 24-bit result as it arrives, marked by a one-cycle valid pulse. It has two watches. One compares the sign-free size of each result with a 16-bit limit and can count how many results go past it. The other keeps a 32-bit running sum of the results and compares it with a 32-bit limit.

Software reaches the block through a simple word-addressed register port with a combinational read path. That port gives access to the limits, the event count, the running sum, the latest result, the status flags and an interrupt mask.

The latest result is held until software reads it. A calibration-done flag, raised by a pulse from the converter's sequencer, shares the status word with the other flags. A single interrupt line combines the flags that the mask enables.

Top module: `adc_thresh_mon`

## Requirements
- R1: With the compare field CFG[1:0] (address 7) nonzero, status bit 1 is set when a result's absolute value is strictly greater than the 16-bit limit at address 3. With the field at 00 the result never sets the bit. The most negative code 0x800000 counts as magnitude 8388608.
- R2: The 16-bit counter at address 4 increments once per result that sets R1's condition, but only when CFG[1] is 1. With the field at 01 the counter does not move. The counter saturates at 0xFFFF, and any write to address 4 clears it.
- R3: A result is copied into the data register (address 2, read sign-extended to 32 bits) only when the ready flag (status bit 0) is clear or the data register is being read in the same cycle. Otherwise the old result is kept. Every result sets the ready flag.
- R4: A read of address 2 clears the ready flag. If a result arrives in the same cycle, that result is captured and the ready flag stays set.
- R5: The accumulate field CFG[3:2] selects the running-sum mode: 00 holds the sum, 01 adds the sign-extended result, and 1x adds the result's magnitude. The sum at address 6 wraps modulo 2^32, and any write to address 6 clears it.
- R6: Status bit 2 is set when, after an update, the running sum is greater than the 32-bit limit at address 5, with both compared as signed numbers.
- R7: Writing a 1 to status bit 1 or bit 2 at address 0 clears that bit. A set in the same cycle wins over the clear.
- R8: A pulse on cal_done sets status bit 3. Any write to the mode register at address 8 (3 bits, read back) clears it.
- R9: The mask at address 1 has the same bit layout as the low eight status bits. irq is high exactly when some status bit and its mask bit are both 1.
- R10: After reset the status, mask, data, counter, sum, limits, configuration and mode all read 0, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | One-cycle pulse marking a new result |
| res_data | input | 24 | Signed conversion result |
| cal_done | input | 1 | Pulse: calibration cycle finished |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Masked interrupt request |

## Verification
The magnitude compare is swept over limits of 0, 1, 100, 0x7FFF and 0xFFFF. At each limit, results of one below, equal to and one above the limit are tried in both signs. This separates a strict from a non-strict compare and a magnitude compare from a raw signed compare. The full-scale codes, including 0x800000, test the edge of the absolute-value logic.

The running sum is driven with mixed-sign sequences in signed mode and in magnitude mode, which tells the two modes apart. A long burst of full-scale results shows the wrap. A burst longer than 65535 results shows counter saturation. Cycle-coincident cases check which action wins in each collision: a read together with a new result, and a flag clear together with a flag set.

// File: rtl/atm_pkg.sv
package atm_pkg;
    localparam int RES_W  = 24;
    localparam int TH_W   = 16;
    localparam int ACC_W  = 32;
    localparam int CNT_W  = 16;
    localparam int STAT_W = 8;
    localparam int MODE_W = 3;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    localparam int B_RDY = 0;
    localparam int B_CMP = 1;
    localparam int B_ACC = 2;
    localparam int B_CAL = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_STAT  = 4'd0,
        A_MASK  = 4'd1,
        A_DATA  = 4'd2,
        A_CMPTH = 4'd3,
        A_CNT   = 4'd4,
        A_ACCTH = 4'd5,
        A_ACC   = 4'd6,
        A_CFG   = 4'd7,
        A_MODE  = 4'd8
    } addr_e;

    typedef struct packed {
        logic [RES_W-1:0]  data;
        logic [STAT_W-1:0] stat;
        logic [STAT_W-1:0] mask;
        logic [TH_W-1:0]   cmp_th;
        logic [CNT_W-1:0]  cnt;
        logic [ACC_W-1:0]  acc_th;
        logic [ACC_W-1:0]  acc;
        logic [1:0]        cmp_en;
        logic [1:0]        acc_en;
        logic [MODE_W-1:0] mode;
    } state_t;
endpackage

// File: rtl/atm_magnitude.sv
module atm_magnitude #(
    parameter int RES_W = 24,
    parameter int TH_W  = 16
) (
    input  logic [RES_W-1:0] res,
    input  logic [TH_W-1:0]  th,
    output logic [RES_W-1:0] mag,
    output logic             over
);
    localparam int PAD_W = RES_W - TH_W;

    always_comb begin
        mag  = res[RES_W-1] ? (~res + 1'b1) : res;
        over = mag > {{PAD_W{1'b0}}, th};
    end
endmodule

// File: rtl/atm_accum.sv
module atm_accum #(
    parameter int RES_W = 24,
    parameter int ACC_W = 32
) (
    input  logic [ACC_W-1:0] base,
    input  logic [RES_W-1:0] res,
    input  logic [RES_W-1:0] mag,
    input  logic [1:0]       sel,
    output logic [ACC_W-1:0] sum
);
    localparam int EXT_W = ACC_W - RES_W;

    logic [ACC_W-1:0] addend;

    always_comb begin
        if (sel[1])
            addend = {{EXT_W{1'b0}}, mag};
        else
            addend = {{EXT_W{res[RES_W-1]}}, res};
        sum = (sel == 2'b00) ? base : base + addend;
    end
endmodule

// File: rtl/atm_irq_merge.sv
module atm_irq_merge #(
    parameter int N = 8
) (
    input  logic [N-1:0] stat,
    input  logic [N-1:0] mask,
    output logic         irq
);
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign hit[i] = stat[i] & mask[i];
    end

    assign irq = |hit;
endmodule

// File: rtl/adc_thresh_mon.sv
module adc_thresh_mon
    import atm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [RES_W-1:0]  res_data,
    input  logic              cal_done,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int              DEXT_W  = DATA_W - RES_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    state_t state_d, state_q;

    logic [RES_W-1:0] mag;
    logic             over;
    logic [ACC_W-1:0] acc_base;
    logic [ACC_W-1:0] acc_sum;
    logic             data_rd;
    logic             acc_clr;

    // names the checker reaches through bind
    logic [RES_W-1:0]  data_q;
    logic              rdy_q;
    logic              cmp_flag_q;
    logic              cal_flag_q;
    logic [STAT_W-1:0] mask_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        cmp_en_q;

    assign data_rd  = reg_rd && (reg_addr == A_DATA);
    assign acc_clr  = reg_wr && (reg_addr == A_ACC);
    assign acc_base = acc_clr ? '0 : state_q.acc;

    atm_magnitude #(.RES_W(RES_W), .TH_W(TH_W)) u_mag (
        .res  (res_data),
        .th   (state_q.cmp_th),
        .mag  (mag),
        .over (over)
    );

    atm_accum #(.RES_W(RES_W), .ACC_W(ACC_W)) u_acc (
        .base (acc_base),
        .res  (res_data),
        .mag  (mag),
        .sel  (state_q.acc_en),
        .sum  (acc_sum)
    );

    atm_irq_merge #(.N(STAT_W)) u_irq (
        .stat (state_q.stat),
        .mask (state_q.mask),
        .irq  (irq)
    );

    always_comb begin
        state_d = state_q;

        // register writes
        if (reg_wr) begin
            case (reg_addr)
                A_STAT: begin
                    if (reg_wdata[B_CMP]) state_d.stat[B_CMP] = 1'b0;
                    if (reg_wdata[B_ACC]) state_d.stat[B_ACC] = 1'b0;
                end
                A_MASK:  state_d.mask   = reg_wdata[STAT_W-1:0];
                A_CMPTH: state_d.cmp_th = reg_wdata[TH_W-1:0];
                A_CNT:   state_d.cnt    = '0;
                A_ACCTH: state_d.acc_th = reg_wdata[ACC_W-1:0];
                A_ACC:   state_d.acc    = '0;
                A_CFG: begin
                    state_d.cmp_en = reg_wdata[1:0];
                    state_d.acc_en = reg_wdata[3:2];
                end
                A_MODE: begin
                    state_d.mode        = reg_wdata[MODE_W-1:0];
                    state_d.stat[B_CAL] = 1'b0;
                end
                default: ;
            endcase
        end

        // read side effect
        if (data_rd)
            state_d.stat[B_RDY] = 1'b0;

        // new result
        if (res_valid) begin
            if (!state_q.stat[B_RDY] || data_rd)
                state_d.data = res_data;
            state_d.stat[B_RDY] = 1'b1;

            if ((state_q.cmp_en != 2'b00) && over) begin
                state_d.stat[B_CMP] = 1'b1;
                if (state_q.cmp_en[1] && (state_d.cnt != CNT_MAX))
                    state_d.cnt = state_d.cnt + 1'b1;
            end

            if (state_q.acc_en != 2'b00) begin
                state_d.acc = acc_sum;
                if ($signed(acc_sum) > $signed(state_q.acc_th))
                    state_d.stat[B_ACC] = 1'b1;
            end
        end

        if (cal_done)
            state_d.stat[B_CAL] = 1'b1;

        // unused status positions stay zero
        state_d.stat[STAT_W-1:B_CAL+1] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STAT:  reg_rdata[STAT_W-1:0] = state_q.stat;
            A_MASK:  reg_rdata[STAT_W-1:0] = state_q.mask;
            A_DATA:  reg_rdata = {{DEXT_W{state_q.data[RES_W-1]}}, state_q.data};
            A_CMPTH: reg_rdata[TH_W-1:0]   = state_q.cmp_th;
            A_CNT:   reg_rdata[CNT_W-1:0]  = state_q.cnt;
            A_ACCTH: reg_rdata[ACC_W-1:0]  = state_q.acc_th;
            A_ACC:   reg_rdata[ACC_W-1:0]  = state_q.acc;
            A_CFG:   reg_rdata[3:0]        = {state_q.acc_en, state_q.cmp_en};
            A_MODE:  reg_rdata[MODE_W-1:0] = state_q.mode;
            default: reg_rdata = '0;
        endcase
    end

    assign data_q     = state_q.data;
    assign rdy_q      = state_q.stat[B_RDY];
    assign cmp_flag_q = state_q.stat[B_CMP];
    assign cal_flag_q = state_q.stat[B_CAL];
    assign mask_q     = state_q.mask;
    assign cnt_q      = state_q.cnt;
    assign cmp_en_q   = state_q.cmp_en;
endmodule

// File: rtl/atm_checker.sv
module atm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        res_valid,
    input logic        cal_done,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [3:0]  reg_addr,
    input logic        irq,
    input logic [23:0] data_q,
    input logic        rdy_q,
    input logic        cmp_flag_q,
    input logic        cal_flag_q,
    input logic [7:0]  mask_q,
    input logic [15:0] cnt_q,
    input logic [1:0]  cmp_en_q
);
    // R1: a disabled compare never raises the magnitude flag
    a_r1_cmp_off: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && cmp_en_q == 2'b00 && !cmp_flag_q) |=> !cmp_flag_q);

    // R2: a saturated counter stays saturated unless cleared
    a_r2_cnt_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == 16'hFFFF && !(reg_wr && reg_addr == 4'd4)) |=> cnt_q == 16'hFFFF);

    // R3: an unread result is not overwritten
    a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_q && !(reg_rd && reg_addr == 4'd2)) |=> $stable(data_q));

    // R4: reading the data register with no new result clears ready
    a_r4_rdy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 4'd2 && !res_valid) |=> !rdy_q);

    // R4: a result always leaves ready set
    a_r4_rdy_set: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> rdy_q);

    // R8: mode write clears calibration-done unless a new pulse arrives
    a_r8_cal_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'd8 && !cal_done) |=> !cal_flag_q);

    // R9: a zero mask never requests an interrupt
    a_r9_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 8'h00) |-> !irq);
endmodule

bind adc_thresh_mon atm_checker u_atm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_valid  (res_valid),
    .cal_done   (cal_done),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .irq        (irq),
    .data_q     (data_q),
    .rdy_q      (rdy_q),
    .cmp_flag_q (cmp_flag_q),
    .cal_flag_q (cal_flag_q),
    .mask_q     (mask_q),
    .cnt_q      (cnt_q),
    .cmp_en_q   (cmp_en_q)
);

// File: tb/test_adc_thresh_mon.sv
module test_adc_thresh_mon;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [23:0] res_data = '0;
    logic        cal_done = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    adc_thresh_mon i_adc_thresh_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_data  (res_data),
        .cal_done  (cal_done),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // hold valid for n rising edges
    task automatic push_n(input int v, input int n);
        @(negedge clk);
        res_valid = 1'b1; res_data = v[23:0];
        repeat (n) @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic push(input int v);
        push_n(v, 1);
    endtask

    function automatic logic [31:0] sx(input int v);
        logic [23:0] t = v[23:0];
        return {{8{t[23]}}, t};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] r;
        int th_list [5] = '{0, 1, 100, 32'h7FFF, 32'hFFFF};
        int seq [12] = '{3, -11, 10, -10, 11, 500, -8388608, 0, 12, -9, 8388607, -1000};
        int ecnt;
        logic [31:0] eacc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset values
        rd(4'd0, r); chk("R10 status", r, 0);
        rd(4'd1, r); chk("R10 mask", r, 0);
        rd(4'd2, r); chk("R10 data", r, 0);
        rd(4'd4, r); chk("R10 counter", r, 0);
        rd(4'd6, r); chk("R10 sum", r, 0);
        rd(4'd7, r); chk("R10 config", r, 0);
        chk("R10 irq", {31'b0, irq}, 0);

        // R1 sweep: strict magnitude compare, both signs
        wr(4'd7, 32'h1);
        foreach (th_list[ti]) begin
            wr(4'd3, th_list[ti]);
            for (int off = -1; off <= 1; off++) begin
                for (int sg = 0; sg < 2; sg++) begin
                    int m = th_list[ti] + off;
                    if (m >= 0) begin
                        int v = sg ? -m : m;
                        wr(4'd0, 32'h6);
                        push(v);
                        rd(4'd0, r);
                        chk("R1 magnitude flag", {30'b0, r[1], r[0]}, {30'b0, m > th_list[ti], 1'b1});
                        rd(4'd2, r);
                        chk("R3 data sign-extended", r, sx(v));
                    end
                end
            end
        end
        rd(4'd4, r); chk("R2 field 01 does not count", r, 0);

        // R1 full-scale codes against the largest limit
        wr(4'd0, 32'h6); push(-8388608); rd(4'd0, r);
        chk("R1 most negative code", {31'b0, r[1]}, 1);
        rd(4'd2, r); chk("R3 most negative data", r, 32'hFF800000);
        wr(4'd0, 32'h6); push(8388607); rd(4'd0, r);
        chk("R1 most positive code", {31'b0, r[1]}, 1);
        rd(4'd2, r);

        // R1 disabled field
        wr(4'd7, 32'h0); wr(4'd3, 0); wr(4'd0, 32'h6);
        push(5); rd(4'd0, r);
        chk("R1 compare off", {31'b0, r[1]}, 0);
        rd(4'd2, r);

        // R2 counting
        wr(4'd7, 32'h2); wr(4'd3, 10);
        ecnt = 0;
        foreach (seq[i]) begin
            push(seq[i]);
            if ((seq[i] < 0 ? -seq[i] : seq[i]) > 10) ecnt++;
        end
        rd(4'd4, r); chk("R2 exceed count", r, ecnt);
        wr(4'd4, 0); rd(4'd4, r); chk("R2 counter clear", r, 0);
        wr(4'd3, 0);
        push_n(1, 65540);
        rd(4'd4, r); chk("R2 saturation", r, 32'hFFFF);
        wr(4'd4, 0);
        rd(4'd2, r);

        // R3 / R4: hold-off and read clears ready
        wr(4'd7, 32'h0);
        push(32'h123456);
        push(32'h000111);
        rd(4'd0, r); chk("R4 ready set", {31'b0, r[0]}, 1);
        rd(4'd2, r); chk("R3 unread result kept", r, 32'h00123456);
        rd(4'd0, r); chk("R4 read clears ready", {31'b0, r[0]}, 0);
        push(-5);
        rd(4'd2, r); chk("R3 new capture after read", r, 32'hFFFFFFFB);
        push(77);
        // R4: read and a new result in the same cycle
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 4'd2; res_valid = 1'b1; res_data = 24'd99;
        #1 r = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; res_valid = 1'b0;
        chk("R4 coincident read returns old", r, 77);
        rd(4'd0, r); chk("R4 coincident ready kept", {31'b0, r[0]}, 1);
        rd(4'd2, r); chk("R4 coincident result captured", r, 99);

        // R5 / R6: running sum
        wr(4'd7, 32'h4); wr(4'd6, 0); wr(4'd5, 100); wr(4'd0, 32'h6);
        push(60); rd(4'd6, r); chk("R5 signed add", r, 60);
        rd(4'd0, r); chk("R6 below limit", {31'b0, r[2]}, 0);
        push(50); rd(4'd6, r); chk("R5 signed add 2", r, 110);
        rd(4'd0, r); chk("R6 above limit", {31'b0, r[2]}, 1);
        wr(4'd0, 32'h4); rd(4'd0, r); chk("R7 clear sum flag", {31'b0, r[2]}, 0);
        push(-200); rd(4'd6, r); chk("R5 negative add", r, 32'(-90));
        wr(4'd7, 32'h8);
        push(-30); rd(4'd6, r); chk("R5 magnitude add", r, 32'(-60));
        wr(4'd7, 32'h0);
        push(1234); rd(4'd6, r); chk("R5 hold mode", r, 32'(-60));
        wr(4'd7, 32'h4); wr(4'd6, 0); wr(4'd5, 32'h7FFFFFFF); wr(4'd0, 32'h6);
        push_n(8388607, 257);
        eacc = 32'(longint'(257) * 8388607);
        rd(4'd6, r); chk("R5 wrap", r, eacc);
        rd(4'd0, r); chk("R6 signed compare after wrap", {31'b0, r[2]}, 0);
        wr(4'd5, 32'hFFFFFFFF); wr(4'd6, 0);
        push(-1); rd(4'd0, r); chk("R6 equal not greater", {31'b0, r[2]}, 0);
        push(2); rd(4'd0, r); chk("R6 signed greater", {31'b0, r[2]}, 1);

        // R7: set wins over clear in the same cycle
        wr(4'd7, 32'h1); wr(4'd3, 0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h2; res_valid = 1'b1; res_data = 24'd9;
        @(negedge clk);
        reg_wr = 1'b0; res_valid = 1'b0;
        rd(4'd0, r); chk("R7 set wins", {31'b0, r[1]}, 1);
        wr(4'd0, 32'h6); rd(4'd0, r); chk("R7 both cleared", {30'b0, r[2:1]}, 0);
        rd(4'd2, r);

        // R8: calibration-done
        @(negedge clk); cal_done = 1'b1; @(negedge clk); cal_done = 1'b0;
        rd(4'd0, r); chk("R8 cal set", {31'b0, r[3]}, 1);

        // R9: mask and interrupt
        #1 chk("R9 masked off", {31'b0, irq}, 0);
        wr(4'd1, 32'h8); rd(4'd1, r); chk("R9 mask readback", r, 8);
        #1 chk("R9 irq enabled", {31'b0, irq}, 1);
        wr(4'd1, 32'h7);
        #1 chk("R9 other bits masked", {31'b0, irq}, 0);

        wr(4'd8, 32'h5);
        rd(4'd0, r); chk("R8 mode write clears cal", {31'b0, r[3]}, 0);
        rd(4'd8, r); chk("R8 mode readback", r, 5);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule